// File: doc/BRIEF.md
# 8b/10b Transmit Encoder with Reset Comma Sequencing

This block turns one or two bytes per clock into 8b/10b code groups for a serial transmitter. Each byte has a flag that selects a control character instead of a data character. A mode input picks between one lane (`dout[9:0]`) and two lanes (`dout[19:0]`). The running disparity carries from lane to lane and from clock to clock, so the output stream stays DC-balanced.

During reset the block drives comma characters (K28.5) with fixed polarity, so the link partner sees a stable pattern. After reset is released it waits for two filler cycles, sends three commas that follow the disparity rules, and then starts encoding its inputs. Any bytes offered before the data phase are dropped.

Top module: `enc8b10b_seq`

## Requirements
- R1: Code groups appear with a = `dout[0]` and j = `dout[9]` (high lane: a = `dout[10]`). K28.5 on negative disparity, abcdeifghj = 0011111010, is the vector 10'h17C. On positive disparity, 1100000101, it is 10'h283. In single-lane mode (`wide`=0), each clock edge that samples `rst` high makes `dout` = {10'h000, 10'h17C}.
- R2: In dual-lane mode (`wide`=1), each clock edge that samples `rst` high makes `dout` = {10'h283, 10'h17C}, whatever state the encoder was in before.
- R3: On the first two edges after `rst` goes low, `dout` keeps its reset value.
- R4: Single-lane mode: edges three, four and five after release give K28.5 on negative, then positive, then negative disparity. Running disparity is positive afterwards.
- R5: Dual-lane mode: edges three, four and five after release each give {10'h283, 10'h17C}. Running disparity is negative afterwards.
- R6: A byte sampled on edge n is output after edge n+1. The first byte that is encoded is the one sampled on the fifth edge after release. Bytes sampled earlier are discarded and are not queued.
- R7: Data characters follow the standard 5b/6b and 3b/4b tables. A sub-block is chosen by the disparity in force before it, and each unbalanced sub-block flips the disparity. Examples in abcdeifghj: D0.0 is 1001110100 on negative and 0110001011 on positive. D3.0 is 1100011011 on negative and 1100010100 on positive. D21.5 is 1010101010 on either disparity.
- R8: For D.x.7 the alternate 3b/4b code is used for x = 17, 18, 20 on negative disparity and for x = 11, 13, 14 on positive disparity. Examples: D17.7 on negative is 1000110111. D11.7 on positive is 1101001000.
- R9: In single-lane mode the first data character uses the positive disparity left by the comma sequence, and disparity chains from clock to clock.
- R10: In dual-lane mode disparity passes from the low lane to the high lane within a clock, and from the high lane to the next clock's low lane. Data starts on negative disparity.
- R11: A byte with its control flag set and value 8'hBC is sent as K28.5 in the column chosen by the current disparity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wide | input | 1 | 0: one byte per clock, 1: two bytes per clock |
| din | input | 16 | Bytes to encode; low lane in [7:0] |
| kin | input | 2 | Control-character flag for each byte |
| dout | output | 20 | Code groups; low lane in [9:0] |

## Verification
The reset pattern is due one edge after `rst` is sampled high. Release fillers and commas are due on edges one through five after the edge that first sees `rst` low. A byte reaches `dout` one edge after it is captured. The bench drives every input on a falling edge and reads `dout` on the next falling edge, after each rising edge, so every read lines up with exactly one register update. Data bytes are offered on every release cycle, and their schedule makes a queued or early byte show up as a mismatch.

// File: rtl/enc8b10b_seq.sv
`timescale 1ns/1ps
module enc8b10b_seq #(
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wide,
  input  logic [8*LANES-1:0]    din,
  input  logic [LANES-1:0]      kin,
  output logic [10*LANES-1:0]   dout
);
  localparam logic [9:0] KNEG = 10'h17C;
  localparam logic [9:0] KPOS = 10'h283;
  localparam logic [2:0] DATA_PH = 3'd5;

  logic [2:0]  cnt;
  logic        rd;
  logic [15:0] d1;
  logic [1:0]  k1;
  logic [10:0] lo, hi;
  logic        live;

  function automatic logic [10:0] enc8b(input logic [7:0] b, input logic k, input logic rdi);
    logic [5:0] s6;
    logic [3:0] s4;
    logic [9:0] w;
    logic [9:0] r;
    logic       rm, alt, k28;
    logic [4:0] x;
    logic [2:0] y;
    x = b[4:0];
    y = b[7:5];
    k28 = k && (x == 5'd28);
    case (x)
      5'd0:  s6 = 6'b100111;  5'd1:  s6 = 6'b011101;
      5'd2:  s6 = 6'b101101;  5'd3:  s6 = 6'b110001;
      5'd4:  s6 = 6'b110101;  5'd5:  s6 = 6'b101001;
      5'd6:  s6 = 6'b011001;  5'd7:  s6 = 6'b111000;
      5'd8:  s6 = 6'b111001;  5'd9:  s6 = 6'b100101;
      5'd10: s6 = 6'b010101;  5'd11: s6 = 6'b110100;
      5'd12: s6 = 6'b001101;  5'd13: s6 = 6'b101100;
      5'd14: s6 = 6'b011100;  5'd15: s6 = 6'b010111;
      5'd16: s6 = 6'b011011;  5'd17: s6 = 6'b100011;
      5'd18: s6 = 6'b010011;  5'd19: s6 = 6'b110010;
      5'd20: s6 = 6'b001011;  5'd21: s6 = 6'b101010;
      5'd22: s6 = 6'b011010;  5'd23: s6 = 6'b111010;
      5'd24: s6 = 6'b110011;  5'd25: s6 = 6'b100110;
      5'd26: s6 = 6'b010110;  5'd27: s6 = 6'b110110;
      5'd28: s6 = 6'b001110;  5'd29: s6 = 6'b101110;
      5'd30: s6 = 6'b011110;  default: s6 = 6'b101011;
    endcase
    if (k28) begin
      s6 = 6'b001111;
      rm = 1'b1;
    end else begin
      rm = rdi ^ ($countones(s6) != 3);
      if (rdi && (($countones(s6) != 3) || (x == 5'd7))) s6 = ~s6;
    end
    alt = (y == 3'd7) && (k || (!rm && (x == 5'd17 || x == 5'd18 || x == 5'd20))
                             || (rm && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    case (y)
      3'd0: s4 = 4'b1011;  3'd1: s4 = 4'b1001;
      3'd2: s4 = 4'b0101;  3'd3: s4 = 4'b1100;
      3'd4: s4 = 4'b1101;  3'd5: s4 = 4'b1010;
      3'd6: s4 = 4'b0110;  default: s4 = alt ? 4'b0111 : 4'b1110;
    endcase
    if (rm && (($countones(s4) != 2) || (y == 3'd3))) s4 = ~s4;
    w = {s6, s4};
    if (k28 && rdi) w = ~w;
    for (int i = 0; i < 10; i++) r[i] = w[9-i];
    return {rdi ^ ($countones(w) != 5), r};
  endfunction

  assign live = (cnt == DATA_PH);
  assign lo = enc8b(live ? d1[7:0]  : 8'hBC, live ? k1[0] : 1'b1, rd);
  assign hi = enc8b(live ? d1[15:8] : 8'hBC, live ? k1[1] : 1'b1, lo[10]);

  always_ff @(posedge clk) begin
    d1 <= din[15:0];
    k1 <= kin[1:0];
    if (rst) begin
      cnt  <= 3'd0;
      rd   <= 1'b0;
      dout <= {wide ? KPOS : 10'h000, KNEG};
    end else begin
      cnt <= live ? cnt : cnt + 3'd1;
      if (cnt >= 3'd2) begin
        dout <= {wide ? hi[9:0] : 10'h000, lo[9:0]};
        rd   <= wide ? hi[10] : lo[10];
      end
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt < 3'd2) |=> $stable(dout));

  assert_weight_R7: assert property (@(posedge clk) disable iff (rst)
    ($countones(dout[9:0]) >= 4 && $countones(dout[9:0]) <= 6));

  assert_column_R7: assert property (@(posedge clk) disable iff (rst)
    ($countones(dout[9:0]) != 5 && !$past(rst)) |-> ($past(rd) == ($countones(dout[9:0]) == 4)));

  assert_chain_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt) >= 3'd2 && !$past(wide))
      |-> (rd == ($past(rd) ^ ($countones(dout[9:0]) != 5))));

  assert_chain_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt) >= 3'd2 && $past(wide))
      |-> (rd == ($past(rd) ^ ($countones(dout[9:0]) != 5) ^ ($countones(dout[19:10]) != 5))));
endmodule

// File: tb/enc8b10b_seq_tb.sv
`timescale 1ns/1ps
module enc8b10b_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wide = 1'b0;
  logic [15:0] din = 16'h0;
  logic [1:0]  kin = 2'b00;
  logic [19:0] dout;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  enc8b10b_seq u_dut (.clk(clk), .rst(rst), .wide(wide), .din(din), .kin(kin), .dout(dout));

  always #10 clk = ~clk;

  function automatic logic [9:0] rv(input logic [9:0] s);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = s[9-i];
    return r;
  endfunction

  localparam logic [9:0] KM = 10'h17C;
  localparam logic [9:0] KP = 10'h283;

  task automatic step(input logic [15:0] d, input logic [1:0] k);
    din = d;
    kin = k;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [19:0] exp, input string tag);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, dout, exp);
    end
  endtask

  task automatic t_reset_single();
    rst = 1'b1; wide = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(16'hFFFF, 2'b11);
      chk({10'h000, KM}, "R1 single reset comma");
    end
  endtask

  task automatic t_release_single();
    rst = 1'b0;
    step(16'h0003, 2'b00); chk({10'h000, KM}, "R3 hold 1");
    step(16'h0003, 2'b00); chk({10'h000, KM}, "R3 hold 2");
    step(16'h0003, 2'b00); chk({10'h000, KM}, "R4 comma neg");
    step(16'h0003, 2'b00); chk({10'h000, KP}, "R4 comma pos");
    step(16'h0000, 2'b00); chk({10'h000, KM}, "R4 comma neg again");
    step(16'h00B5, 2'b00); chk({10'h000, rv(10'b0110001011)}, "R6 R9 D0.0 on positive");
    step(16'h0003, 2'b00); chk({10'h000, rv(10'b1010101010)}, "R7 D21.5");
    step(16'h00F1, 2'b00); chk({10'h000, rv(10'b1100010100)}, "R7 D3.0 on positive");
    step(16'h00EB, 2'b00); chk({10'h000, rv(10'b1000110111)}, "R8 D17.7 alternate on negative");
    step(16'h00BC, 2'b01); chk({10'h000, rv(10'b1101001000)}, "R8 D11.7 alternate on positive");
    step(16'h0000, 2'b00); chk({10'h000, KM}, "R11 K28.5 on negative");
  endtask

  task automatic t_double();
    rst = 1'b1; wide = 1'b1;
    step(16'hFFFF, 2'b00); chk({KP, KM}, "R2 double reset comma");
    step(16'hFFFF, 2'b00); chk({KP, KM}, "R2 double reset comma held");
    rst = 1'b0;
    step(16'h0303, 2'b00); chk({KP, KM}, "R3 double hold 1");
    step(16'h0303, 2'b00); chk({KP, KM}, "R3 double hold 2");
    for (int i = 0; i < 2; i++) begin
      step(16'h0303, 2'b00); chk({KP, KM}, "R5 double comma");
    end
    step(16'h0000, 2'b00); chk({KP, KM}, "R5 double comma last");
    step(16'h0303, 2'b00);
    chk({rv(10'b1001110100), rv(10'b1001110100)}, "R6 R10 D0.0 both lanes on negative");
    step(16'hEBF1, 2'b00);
    chk({rv(10'b1100010100), rv(10'b1100011011)}, "R10 D3.0 chain low to high");
    step(16'hB503, 2'b00);
    chk({rv(10'b1101001000), rv(10'b1000110111)}, "R8 R10 D17.7 then D11.7");
    step(16'hBC03, 2'b10);
    chk({rv(10'b1010101010), rv(10'b1100011011)}, "R10 D3.0 then D21.5");
    step(16'h0000, 2'b00);
    chk({KM, rv(10'b1100010100)}, "R10 R11 chain high to next low");
    rst = 1'b1;
    step(16'h0000, 2'b00); chk({KP, KM}, "R2 reset mid-stream");
  endtask

  initial begin
    @(negedge clk);
    t_reset_single();
    t_release_single();
    t_double();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule